// File: doc/BRIEF.md
# Fault Record Logger

This block stores short snapshots of a supervisory sequencer into a region of byte-wide nonvolatile memory that only ever grows. Each snapshot is one fixed 8-byte record placed in the next free slot. The sequencer pulses `trig` when it enters a state marked for logging and presents the snapshot fields on the same cycle. The block latches those fields and writes the eight bytes one at a time. Before each byte it waits for the memory to report that it is no longer busy.

Every slot carries a flag bit in bit 7 of its first byte. An erased slot reads 1 there, and the block writes 0 there once the record is complete. On reset, and on the recorder reset input, the block reads the flag bytes in ascending slot order. The first slot that still reads 1 becomes the write position. If no slot reads 1, the region is full and no further records are written. The block never erases, so the first fault of a cascade is the record that survives. A trigger that arrives while the block is busy is dropped and sets a sticky overflow flag.

The controller has five named states:
- **SCAN_REQ** waits until the memory is idle, issues a read of the current slot's flag byte, then moves to SCAN_WAIT.
- **SCAN_WAIT** examines the returned byte:
  - If the flag is 1, it stops in IDLE.
  - If the flag is 0 and the slot is the last one, it marks the region full and goes to IDLE.
  - Otherwise it advances the slot and returns to SCAN_REQ.
- **IDLE** latches the snapshot on a trigger when the region is not full, then moves to WR_ISSUE.
- **WR_ISSUE** waits until the memory is idle, strobes one byte, then moves to WR_WAIT.
- **WR_WAIT** waits until the memory is idle. If the flag byte has been written, it advances the slot and goes to IDLE. Otherwise it goes to WR_ISSUE for the next byte.

A recorder reset forces SCAN_REQ from any state.

Top module: `frec_logger`

## Requirements
- R1: After `rst_n` is released or `rec_rst` is pulsed, the block raises `busy`, clears `full`, and reads the flag byte (address BASE_ADDR + 8*slot) of slots 0, 1, 2, … in order, one `mem_rd` per slot. The read data is taken on the cycle after the strobe. The first slot whose byte has bit 7 = 1 becomes the write slot, and `busy` falls once that slot is found.
- R2: If every slot's flag bit reads 0, `full` is asserted when the scan ends. A trigger while `full` and idle causes no memory write and does not set `overflow`.
- R3: Record byte layout:
  - byte 0 = {flag 0, state[5:0], 0}
  - byte 1 = {000000, cause[1:0]}, with cause codes 0 = sequence, 1 = timeout, 2 = monitor
  - byte 2 = UV status
  - byte 3 = OV status
  - byte 4 = GPI status
  - byte 5 = limit[7:0]
  - byte 6 = limit[15:8]
- R4: Byte 7 is the two's complement of the 8-bit sum of bytes 0 to 6, so all eight bytes sum to 0 modulo 256.
- R5: The bytes of a record are written at offsets 1, 2, …, 7 and then 0. The flag byte is therefore last, and it is written with bit 7 = 0.
- R6: Each `mem_wr` lasts one cycle and is never issued while `mem_busy` is high. The memory raises `mem_busy` from the cycle after a strobe until its write completes.
- R7: A trigger while `busy` is dropped and sets `overflow`. `overflow` stays set until `rst_n` or `rec_rst`.
- R8: After the record in the last slot completes, `full` is set and no further write occurs.
- R9: A `rec_rst` during a record abandons it with no further write. Because the flag byte was not yet written, the rescan selects that same slot.
- R10: Successive records go to successive slots at address BASE_ADDR + 8*slot + offset. A slot is never chosen again once its flag is written.
- R11: The snapshot fields are latched on the accepted trigger. Changes to them afterwards do not alter the record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; starts a scan |
| rec_rst | input | 1 | Synchronous recorder reset; aborts and rescans, clears overflow |
| trig | input | 1 | Record request pulse |
| snap_state | input | 6 | Number of the state being left |
| snap_cause | input | 2 | Exit cause code |
| snap_uv | input | 8 | Undervoltage comparator status |
| snap_ov | input | 8 | Overvoltage comparator status |
| snap_gpi | input | 8 | General-purpose input status |
| snap_limit | input | 16 | Limit comparator status |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_wr | output | 1 | One-cycle write strobe |
| mem_rd | output | 1 | One-cycle read strobe |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| mem_busy | input | 1 | Memory write in progress |
| busy | output | 1 | Scanning or writing |
| full | output | 1 | No free slot left |
| overflow | output | 1 | Sticky: a trigger was dropped while busy |

## Verification
The scan is tried from three starting points:
- three used slots, which shows the scan stops at the first erased flag;
- a slot holding a partly written record, which shows the flag is written last;
- an entirely used region, which shows the full path and the ignored trigger.

Records carry varied state numbers, causes and status bytes, so a swapped field, a wrong bit position or a wrong checksum shows up as a byte mismatch. The write order is compared strobe by strobe. Triggers are also sent while the block is busy and after the fields change, which separates dropping a trigger from re-latching its fields.

// File: rtl/frec_pkg.sv
package frec_pkg;

    // Fixed record geometry.
    localparam int REC_BYTES = 8;
    localparam int OFF_W     = 3;

    typedef enum logic [2:0] {
        ST_SCAN_REQ,
        ST_SCAN_WAIT,
        ST_IDLE,
        ST_WR_ISSUE,
        ST_WR_WAIT
    } lg_state_e;

    typedef struct packed {
        logic [5:0]  state_no;
        logic [1:0]  cause;
        logic [7:0]  uv;
        logic [7:0]  ov;
        logic [7:0]  gpi;
        logic [15:0] limit;
    } snap_t;

endpackage

// File: rtl/frec_record_fmt.sv
module frec_record_fmt
    import frec_pkg::*;
(
    input  snap_t            snap,
    input  logic [OFF_W-1:0] off,
    output logic [7:0]       data
);

    logic [7:0] body [REC_BYTES];
    logic [7:0] sum;

    always_comb begin
        // Byte 0 carries the written flag (0) in bit 7.
        body[0] = {1'b0, snap.state_no, 1'b0};
        body[1] = {6'b0, snap.cause};
        body[2] = snap.uv;
        body[3] = snap.ov;
        body[4] = snap.gpi;
        body[5] = snap.limit[7:0];
        body[6] = snap.limit[15:8];
        sum = 8'd0;
        for (int i = 0; i < REC_BYTES - 1; i++) begin
            sum = sum + body[i];
        end
        body[REC_BYTES-1] = 8'd0 - sum;
    end

    assign data = body[off];

endmodule

// File: rtl/frec_slot_tracker.sv
module frec_slot_tracker #(
    parameter int SLOTS  = 16,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step,
    output logic [SLOT_W-1:0] slot,
    output logic              last,
    output logic              full
);

    assign last = (slot == SLOT_W'(SLOTS - 1));

    // One advance rule serves both the scan and a completed record.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot <= '0;
            full <= 1'b0;
        end else if (clr) begin
            slot <= '0;
            full <= 1'b0;
        end else if (step) begin
            if (last) begin
                full <= 1'b1;
            end else begin
                slot <= slot + SLOT_W'(1);
            end
        end
    end

endmodule

// File: rtl/frec_logger.sv
module frec_logger
    import frec_pkg::*;
#(
    parameter int              SLOTS     = 16,
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rec_rst,
    input  logic              trig,
    input  logic [5:0]        snap_state,
    input  logic [1:0]        snap_cause,
    input  logic [7:0]        snap_uv,
    input  logic [7:0]        snap_ov,
    input  logic [7:0]        snap_gpi,
    input  logic [15:0]       snap_limit,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_wr,
    output logic              mem_rd,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_busy,
    output logic              busy,
    output logic              full,
    output logic              overflow
);

    localparam int SLOT_W = $clog2(SLOTS);
    localparam logic [OFF_W-1:0] LAST_K = OFF_W'(REC_BYTES - 1);

    lg_state_e         state, nxt;
    logic [OFF_W-1:0]  k;
    logic [OFF_W-1:0]  off;
    logic [SLOT_W-1:0] slot;
    logic              slot_last;
    logic              step;
    logic              flag_free;
    logic              rdata_unused;
    logic              accept;
    logic              byte_done;
    snap_t             snap_q;

    assign flag_free    = mem_rdata[7];
    assign rdata_unused = ^mem_rdata[6:0];
    assign accept       = (state == ST_IDLE) && trig && !full && !rec_rst;
    assign byte_done    = (state == ST_WR_WAIT) && !mem_busy;

    assign step = ((state == ST_SCAN_WAIT) && !flag_free)
                || (byte_done && (k == LAST_K));

    frec_slot_tracker #(.SLOTS(SLOTS)) u_track (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rec_rst),
        .step  (step),
        .slot  (slot),
        .last  (slot_last),
        .full  (full)
    );

    frec_record_fmt u_fmt (
        .snap (snap_q),
        .off  (off),
        .data (mem_wdata)
    );

    // Next-state logic.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_SCAN_REQ:  if (!mem_busy) nxt = ST_SCAN_WAIT;
            ST_SCAN_WAIT: nxt = (flag_free || slot_last) ? ST_IDLE : ST_SCAN_REQ;
            ST_IDLE:      if (trig && !full) nxt = ST_WR_ISSUE;
            ST_WR_ISSUE:  if (!mem_busy) nxt = ST_WR_WAIT;
            ST_WR_WAIT:   if (!mem_busy) nxt = (k == LAST_K) ? ST_IDLE : ST_WR_ISSUE;
            default:      nxt = ST_IDLE;
        endcase
        if (rec_rst) nxt = ST_SCAN_REQ;
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_SCAN_REQ;
        else        state <= nxt;
    end

    // Datapath registers: byte counter, snapshot latch, overflow.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k        <= '0;
            snap_q   <= '0;
            overflow <= 1'b0;
        end else begin
            if (accept) begin
                k      <= '0;
                snap_q <= '{state_no: snap_state, cause: snap_cause, uv: snap_uv,
                            ov: snap_ov, gpi: snap_gpi, limit: snap_limit};
            end else if (byte_done && (k != LAST_K)) begin
                k <= k + OFF_W'(1);
            end
            if (rec_rst)                          overflow <= 1'b0;
            else if (trig && (state != ST_IDLE))  overflow <= 1'b1;
        end
    end

    // Outputs: body offsets 1..7 first, flag byte (offset 0) last.
    always_comb begin
        off    = '0;
        mem_rd = 1'b0;
        mem_wr = 1'b0;
        unique case (state)
            ST_SCAN_REQ:  mem_rd = !mem_busy && !rec_rst;
            ST_WR_ISSUE: begin
                off    = k + OFF_W'(1);
                mem_wr = !mem_busy && !rec_rst;
            end
            ST_WR_WAIT:   off = k + OFF_W'(1);
            default:      off = '0;
        endcase
        mem_addr = BASE_ADDR + ADDR_W'({slot, off});
        busy     = (state != ST_IDLE);
    end

endmodule

// File: rtl/frec_logger_chk.sv
module frec_logger_chk
    import frec_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h80
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rec_rst,
    input logic              trig,
    input logic              busy,
    input logic              full,
    input logic              overflow,
    input logic              mem_wr,
    input logic              mem_rd,
    input logic              mem_busy,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_wdata
);

    a_r6_no_strobe_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> !mem_busy);

    a_r6_single_cycle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_wr);

    a_r1_read_write_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr && mem_rd));

    a_r1_scan_reads_flag_byte: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (mem_addr[OFF_W-1:0] == '0) && (mem_addr >= BASE_ADDR));

    a_r1_rrst_starts_scan: assert property (@(posedge clk) disable iff (!rst_n)
        rec_rst |=> (busy && !full && !overflow));

    a_r5_flag_written_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && (mem_addr[OFF_W-1:0] == '0)) |-> !mem_wdata[7]);

    a_r7_overflow_set: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && busy && !rec_rst) |=> overflow);

    a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !rec_rst) |=> overflow);

    a_r8_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !mem_wr);

    a_r2_full_ignores_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !busy && trig && !rec_rst) |=> !busy);

endmodule

bind frec_logger frec_logger_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rec_rst   (rec_rst),
    .trig      (trig),
    .busy      (busy),
    .full      (full),
    .overflow  (overflow),
    .mem_wr    (mem_wr),
    .mem_rd    (mem_rd),
    .mem_busy  (mem_busy),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
);

// File: tb/frec_logger_bench.sv
module frec_logger_bench;

    localparam int CLK_PERIOD = 10;
    localparam int SLOTS      = 16;
    localparam int BASE       = 128;
    localparam int MEM_WAIT   = 6;
    localparam int WD_CYCLES  = 50000;

    typedef struct packed {
        logic [7:0] a;
        logic [7:0] d;
    } xfer_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rec_rst = 1'b0;
    logic        trig = 1'b0;
    logic [5:0]  snap_state = '0;
    logic [1:0]  snap_cause = '0;
    logic [7:0]  snap_uv = '0, snap_ov = '0, snap_gpi = '0;
    logic [15:0] snap_limit = '0;
    logic [7:0]  mem_addr, mem_wdata;
    logic        mem_wr, mem_rd;
    logic [7:0]  mem_rdata = '0;
    logic        mem_busy;
    logic        busy, full, overflow;

    int total = 0;
    int bad   = 0;
    int m_ptr = 0;
    bit m_full = 1'b0;
    xfer_t      wq[$];
    logic [7:0] rq[$];

    logic [7:0] mem [256];
    int cnt = 0;
    int wr_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frec_logger u_frec_logger (
        .clk(clk), .rst_n(rst_n), .rec_rst(rec_rst), .trig(trig),
        .snap_state(snap_state), .snap_cause(snap_cause), .snap_uv(snap_uv),
        .snap_ov(snap_ov), .snap_gpi(snap_gpi), .snap_limit(snap_limit),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wr(mem_wr), .mem_rd(mem_rd),
        .mem_rdata(mem_rdata), .mem_busy(mem_busy),
        .busy(busy), .full(full), .overflow(overflow)
    );

    // Memory stub: busy from the cycle after a write strobe, registered reads.
    assign mem_busy = (cnt != 0);
    always @(posedge clk) begin
        if (mem_wr) begin
            mem[mem_addr] <= mem_wdata;
            cnt    <= MEM_WAIT;
            wr_cnt <= wr_cnt + 1;
        end else if (cnt != 0) begin
            cnt <= cnt - 1;
        end
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-clock comparison of every memory strobe against the model's queues.
    always @(negedge clk) begin : mon
        xfer_t e;
        logic [7:0] ra;
        if (rst_n) begin
            if (mem_wr) begin
                chk(!mem_busy, "R6 write strobe while memory busy", 1, 0);
                if (wq.size() == 0) begin
                    chk(1'b0, "R10 R8 R2 unexpected write", mem_addr, 0);
                end else begin
                    e = wq.pop_front();
                    chk(mem_addr == e.a, "R5 R10 write address order", mem_addr, e.a);
                    if (e.a[2:0] == 3'd0)
                        chk(mem_wdata == e.d, "R5 flag byte", mem_wdata, e.d);
                    else if (e.a[2:0] == 3'd7)
                        chk(mem_wdata == e.d, "R4 checksum byte", mem_wdata, e.d);
                    else
                        chk(mem_wdata == e.d, "R3 R11 field byte", mem_wdata, e.d);
                end
            end
            if (mem_rd) begin
                if (rq.size() == 0) begin
                    chk(1'b0, "R1 unexpected scan read", mem_addr, 0);
                end else begin
                    ra = rq.pop_front();
                    chk(mem_addr == ra, "R1 scan read address", mem_addr, ra);
                end
            end
        end
    end

    function automatic logic [7:0] rec_byte(int st, int ca, int uv, int ov, int gp, int lm, int off);
        logic [7:0] b [8];
        logic [7:0] s;
        b[0] = 8'(st << 1);
        b[1] = 8'(ca & 3);
        b[2] = 8'(uv);
        b[3] = 8'(ov);
        b[4] = 8'(gp);
        b[5] = 8'(lm);
        b[6] = 8'(lm >> 8);
        s = 8'd0;
        for (int i = 0; i < 7; i++) s = s + b[i];
        b[7] = 8'd0 - s;
        return b[off];
    endfunction

    task automatic model_scan();
        m_full = 1'b1;
        for (int i = 0; i < SLOTS; i++) begin
            rq.push_back(8'(BASE + 8 * i));
            if (mem[BASE + 8 * i][7]) begin
                m_ptr  = i;
                m_full = 1'b0;
                break;
            end
        end
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic fire(int st, int ca, int uv, int ov, int gp, int lm);
        @(negedge clk);
        snap_state = 6'(st); snap_cause = 2'(ca); snap_uv = 8'(uv);
        snap_ov = 8'(ov); snap_gpi = 8'(gp); snap_limit = 16'(lm);
        trig = 1'b1;
        if (!m_full) begin
            for (int k = 0; k < 8; k++) begin
                int off = (k + 1) % 8;
                wq.push_back('{a: 8'(BASE + 8 * m_ptr + off),
                               d: rec_byte(st, ca, uv, ov, gp, lm, off)});
            end
            if (m_ptr == SLOTS - 1) m_full = 1'b1;
            else                    m_ptr++;
        end
        @(negedge clk);
        trig = 1'b0;
    endtask

    initial begin : wd
        repeat (WD_CYCLES) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
        for (int i = 0; i < 3; i++) mem[BASE + 8 * i] = 8'h0A;
        model_scan();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state: scanning, not full, no overflow
        chk(busy == 1'b1, "R1 busy during scan", busy, 1);
        chk(full == 1'b0, "R1 full after reset", full, 0);
        chk(overflow == 1'b0, "R7 overflow after reset", overflow, 0);
        wait_idle();
        chk(rq.size() == 0, "R1 scan stopped at slot 3", rq.size(), 0);
        chk(full == 1'b0, "R1 not full", full, 0);

        // R3 R4 R5: first record, timeout cause
        fire(5, 1, 8'h11, 8'h22, 8'h33, 16'hA55A);
        wait_idle();
        chk(mem[BASE + 24][7] == 1'b0, "R5 slot 3 flag cleared", mem[BASE + 24], 8'h0A);

        // R7 R11: busy trigger dropped, fields changed after acceptance
        fire(63, 2, 8'hFF, 8'h00, 8'h80, 16'h0102);
        @(negedge clk);
        snap_state = 6'd9; snap_uv = 8'h5C; snap_limit = 16'hFFFF;
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        chk(overflow == 1'b1, "R7 overflow after busy trigger", overflow, 1);
        wait_idle();
        chk(overflow == 1'b1, "R7 overflow sticky", overflow, 1);

        // R9: recorder reset part-way through a record in slot 5
        begin
            int base_w;
            base_w = wr_cnt;
            fire(12, 0, 8'h01, 8'h02, 8'h04, 16'h0008);
            while (wr_cnt < base_w + 3) @(negedge clk);
            rec_rst = 1'b1;
            wq.delete();
            model_scan();
            chk(m_ptr == 5 && !m_full, "R9 partial slot still free", m_ptr, 5);
            @(negedge clk);
            rec_rst = 1'b0;
            chk(overflow == 1'b0, "R7 overflow cleared by recorder reset", overflow, 0);
            chk(busy == 1'b1, "R1 busy after recorder reset", busy, 1);
            wait_idle();
            chk(rq.size() == 0, "R9 rescan reads", rq.size(), 0);
        end

        // R10 R8: fill slots 5..15
        for (int i = 0; i < 11; i++) begin
            fire(i + 20, i % 3, i * 7, 255 - i, i * 16, i * 1000);
            wait_idle();
            if (i < 10) chk(full == 1'b0, "R8 not full before last slot", full, 0);
        end
        chk(full == 1'b1, "R8 full after last slot", full, 1);
        fire(1, 0, 1, 1, 1, 1);
        repeat (20) @(negedge clk);
        chk(busy == 1'b0, "R8 trigger ignored when full", busy, 0);
        chk(overflow == 1'b0, "R2 ignored trigger sets no overflow", overflow, 0);

        // R2: rescan of a fully used region
        @(negedge clk);
        rec_rst = 1'b1;
        model_scan();
        @(negedge clk);
        rec_rst = 1'b0;
        chk(full == 1'b0, "R1 full cleared at rescan", full, 0);
        wait_idle();
        chk(full == 1'b1 && m_full, "R2 full after scanning used region", full, 1);
        fire(2, 2, 2, 2, 2, 2);
        repeat (20) @(negedge clk);
        chk(busy == 1'b0, "R2 trigger ignored when full", busy, 0);

        chk(wq.size() == 0 && rq.size() == 0, "R10 all expected transfers seen",
            wq.size() + rq.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule